// File: doc/BRIEF.md
# Guarded Protection-Status Write Controller

This block is the slave-side command decoder that owns the protection fields of a serial flash status register: a two-bit block-protect field and a lock bit. It watches the serial clock, active-low chip select, serial data input and an active-low write-protect pin. All four are sampled by a fast system clock, so the serial side may run in either idle polarity. Each framed command begins with an 8-bit opcode, sent MSB first. A status write carries a second byte whose bits 7, 3 and 2 become the lock bit and the protect bits.

A status write is honoured only when the command completed just before it was the arming opcode. When the write-protect pin is low and the lock bit is set, the register is frozen. Every decision is made, and every change is committed, when chip select returns high.

A frame walks the states `ST_IDLE` → `ST_OPCODE` on a chip-select fall. When the first byte is a status write, it moves `ST_OPCODE` → `ST_DATA`. For any other opcode it moves `ST_OPCODE` → `ST_TAIL`. After the data byte it moves `ST_DATA` → `ST_TAIL`. Any state returns to `ST_IDLE` on a chip-select rise, and that rise is where the frame is evaluated.

Top module: `sr_status_guard`

## Requirements
- R1: After reset the protect field reads 2'b11, the lock bit reads 0, and no arm is pending, so a status write sent straight after reset changes nothing.
- R2: Opcode 8'h50 arms a status write. Opcode 8'h01 followed by one data byte is the status write. Bits are taken MSB first. Data bit 7 goes to the lock bit, and data bits 3 and 2 go to protect bits 1 and 0. All other data bits are ignored.
- R3: Bits are sampled on rising serial-clock edges while chip select is low, so frames sent with the clock idling low and frames sent with it idling high give the same result.
- R4: A frame of 8 or more bits arms the write when its opcode is 8'h50 and disarms it for any other opcode. A frame of fewer than 8 bits leaves the arm unchanged.
- R5: With write-protect low and the lock bit set, a status write changes neither the lock bit nor the protect field.
- R6: With write-protect low and the lock bit clear, a status write may set the lock bit and change the protect field in the same command.
- R7: With write-protect high, the lock bit and the protect field can each be written to 0 or to 1.
- R8: Write-protect is judged at the chip-select rise that ends the command, and the status fields change only at such a rise.
- R9: A status-write frame with fewer than 16 bits is discarded. Bits clocked after the 16th are ignored.
- R10: Every status-write frame of 8 or more bits consumes the arm, so a second status write without a fresh 8'h50 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock |
| cs_n_i | input | 1 | Active-low chip select framing one command |
| si_i | input | 1 | Serial data in, MSB first |
| wp_n_i | input | 1 | Active-low write-protect pin |
| bp_o | output | 2 | Current block-protect field |
| bpl_o | output | 1 | Current lock bit |

## Verification
Status writes are run under every combination of the write-protect level and the lock-bit state. This separates the frozen case from the one-way-lock case and from the unlocked case. Arm handling is probed with several sequences: an arm followed directly by a write, a write with no arm, a foreign opcode placed between arm and write, a truncated frame placed between them, and a repeated arm. Together these separate "previous completed command" from "any earlier arm". Data bytes with stray bits set, short frames, overlong frames and both clock idle levels cover field positions and framing. Toggling write-protect in the middle of a frame shows the level is judged at chip-select rise and not at frame start.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OPCODE = 2'd1,
        ST_DATA   = 2'd2,
        ST_TAIL   = 2'd3
    } frame_state_e;

    localparam int          BYTE_W    = 8;
    localparam int          BP_W      = 2;
    localparam logic [7:0]  OP_ARM    = 8'h50;
    localparam logic [7:0]  OP_WRITE  = 8'h01;
    localparam int          POS_LOCK  = 7;
    localparam int          POS_BP_HI = 3;
    localparam int          POS_BP_LO = 2;
endpackage

// File: rtl/sr_input_sync.sv
module sr_input_sync #(
    parameter int               STAGES    = 2,
    parameter int               WIDTH     = 4,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RESET_VAL;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RESET_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sr_edge_detect.sv
module sr_edge_detect #(
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE_VAL;
        else        prev_q <= sig;
    end

    assign rise = sig & ~prev_q;
    assign fall = ~sig & prev_q;
endmodule

// File: rtl/sr_byte_shifter.sv
module sr_byte_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_done
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            done_q  <= 1'b0;
        end else if (clear) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= shift_en && (cnt_q == LAST);
            if (shift_en) begin
                shreg_q <= {shreg_q[BYTE_W-2:0], bit_in};
                cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
        end
    end

    assign byte_o    = shreg_q;
    assign byte_done = done_q;

    // R2
    done_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(shift_en));
endmodule

// File: rtl/sr_status_guard.sv
module sr_status_guard
    import sr_guard_pkg::*;
#(
    parameter int             SYNC_STAGES = 2,
    parameter logic [BP_W-1:0] BP_RESET   = 2'b11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sck_i,
    input  logic            cs_n_i,
    input  logic            si_i,
    input  logic            wp_n_i,
    output logic [BP_W-1:0] bp_o,
    output logic            bpl_o
);
    logic s_sck, s_cs_n, s_si, s_wp_n;
    logic cs_rise, cs_fall, sck_rise, sck_fall_unused;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_done;

    frame_state_e state_q, state_d;
    logic [BYTE_W-1:0] opcode_q;
    logic              new_lock_q;
    logic [BP_W-1:0]   new_bp_q;
    logic              arm_q;
    logic              bpl_q;
    logic [BP_W-1:0]   bp_q;

    sr_input_sync #(.STAGES(SYNC_STAGES), .WIDTH(4), .RESET_VAL(4'b1111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_i, cs_n_i, si_i, wp_n_i}),
        .q     ({s_sck, s_cs_n, s_si, s_wp_n})
    );

    sr_edge_detect #(.IDLE_VAL(1'b1)) u_cs_edge (
        .clk (clk), .rst_n (rst_n), .sig (s_cs_n),
        .rise (cs_rise), .fall (cs_fall)
    );

    sr_edge_detect #(.IDLE_VAL(1'b1)) u_sck_edge (
        .clk (clk), .rst_n (rst_n), .sig (s_sck),
        .rise (sck_rise), .fall (sck_fall_unused)
    );

    sr_byte_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cs_fall),
        .shift_en  (sck_rise && !s_cs_n),
        .bit_in    (s_si),
        .byte_o    (rx_byte),
        .byte_done (rx_done)
    );

    // Frame evaluation at chip-select rise
    logic op_complete, wr_frame, wr_blocked, wr_commit;
    assign op_complete = cs_rise && (state_q == ST_DATA || state_q == ST_TAIL);
    assign wr_frame    = op_complete && (opcode_q == OP_WRITE);
    assign wr_blocked  = !s_wp_n && bpl_q;
    assign wr_commit   = wr_frame && (state_q == ST_TAIL) && arm_q && !wr_blocked;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_fall) state_d = ST_OPCODE;
            ST_OPCODE: begin
                if (cs_rise)      state_d = ST_IDLE;
                else if (rx_done) state_d = (rx_byte == OP_WRITE) ? ST_DATA : ST_TAIL;
            end
            ST_DATA: begin
                if (cs_rise)      state_d = ST_IDLE;
                else if (rx_done) state_d = ST_TAIL;
            end
            ST_TAIL:   if (cs_rise) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Captured fields, arm and status outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode_q   <= '0;
            new_lock_q <= 1'b0;
            new_bp_q   <= '0;
            arm_q      <= 1'b0;
            bpl_q      <= 1'b0;
            bp_q       <= BP_RESET;
        end else begin
            if (state_q == ST_OPCODE && rx_done && !cs_rise)
                opcode_q <= rx_byte;
            if (state_q == ST_DATA && rx_done && !cs_rise) begin
                new_lock_q <= rx_byte[POS_LOCK];
                new_bp_q   <= {rx_byte[POS_BP_HI], rx_byte[POS_BP_LO]};
            end
            if (op_complete)
                arm_q <= (opcode_q == OP_ARM);
            if (wr_commit) begin
                bpl_q <= new_lock_q;
                bp_q  <= new_bp_q;
            end
        end
    end

    assign bp_o  = bp_q;
    assign bpl_o = bpl_q;

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bpl_q && !s_wp_n) |=> (bpl_q && $stable(bp_q)));

    // R8
    commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> ($stable(bpl_q) && $stable(bp_q)));

    // R4
    arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm_q) |-> $past(cs_rise && opcode_q == OP_ARM));

    // R10
    write_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !arm_q) |=> ($stable(bpl_q) && $stable(bp_q)));

    // R8
    idle_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_cs_n && !cs_rise) |-> (state_q == ST_IDLE));
endmodule

// File: tb/tb_sr_status_guard.sv
module tb_sr_status_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       si = 1'b0;
    logic       wp_n = 1'b1;
    logic [1:0] bp;
    logic       bpl;
    int         n_tests = 0;
    int         n_fail = 0;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    sr_status_guard dut (
        .clk (clk), .rst_n (rst_n), .sck_i (sck), .cs_n_i (cs_n),
        .si_i (si), .wp_n_i (wp_n), .bp_o (bp), .bpl_o (bpl)
    );

    // {arm_first, wp_n, mode3, opcode, data, nbits, expected {bpl,bp1,bp0}}, req tag
    localparam int NV = 10;
    localparam logic [29:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b0, 8'h01, 8'h00, 8'd16, 3'b000}, // R7 clear all
        {1'b0, 1'b1, 1'b0, 8'h01, 8'h0C, 8'd16, 3'b000}, // R10 no fresh arm
        {1'b1, 1'b1, 1'b1, 8'h01, 8'h0C, 8'd16, 3'b011}, // R3 mode 3
        {1'b1, 1'b1, 1'b0, 8'h01, 8'h73, 8'd16, 3'b000}, // R2 stray bits ignored
        {1'b1, 1'b0, 1'b0, 8'h01, 8'h84, 8'd16, 3'b101}, // R6 set lock with wp low
        {1'b1, 1'b0, 1'b1, 8'h01, 8'h00, 8'd16, 3'b101}, // R5 frozen
        {1'b1, 1'b1, 1'b0, 8'h01, 8'h08, 8'd16, 3'b010}, // R7 unlock with wp high
        {1'b1, 1'b1, 1'b0, 8'h01, 8'hFF, 8'd12, 3'b010}, // R9 short frame
        {1'b1, 1'b1, 1'b1, 8'h01, 8'h8C, 8'd16, 3'b111}, // R7 set all
        {1'b1, 1'b1, 1'b0, 8'h01, 8'h00, 8'd20, 3'b000}  // R9 overlong frame
    };
    localparam int VREQ [NV] = '{7, 10, 3, 2, 6, 5, 7, 9, 7, 9};

    task automatic check(input int req, input logic [2:0] exp);
        n_tests++;
        if ({bpl, bp} !== exp) begin
            n_fail++;
            $display("FAIL R%0d: status actual=%b expected=%b", req, {bpl, bp}, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] op, input logic [7:0] dat,
                              input int nbits, input logic m3, input logic wp_end);
        logic [15:0] w;
        w = {op, dat};
        sck = m3;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sck = 1'b0;
            si  = (i < 16) ? w[15-i] : 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b1;
            repeat (4) @(negedge clk);
        end
        if (!m3) sck = 1'b0;
        repeat (4) @(negedge clk);
        wp_n = wp_end;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(1, 3'b011); // R1 reset state

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][29]) send_frame(8'h50, 8'h00, 8, VEC[v][27], VEC[v][28]);
            wp_n = VEC[v][28];
            send_frame(VEC[v][26:19], VEC[v][18:11], int'(VEC[v][10:3]), VEC[v][27], VEC[v][28]);
            check(VREQ[v], VEC[v][2:0]);
        end

        // R4: foreign opcode between arm and write disarms
        send_frame(8'h50, 8'h00, 8, 1'b0, 1'b1);
        send_frame(8'h05, 8'h00, 8, 1'b0, 1'b1);
        send_frame(8'h01, 8'h0C, 16, 1'b0, 1'b1);
        check(4, 3'b000);

        // R4: truncated frame between arm and write keeps the arm
        send_frame(8'h50, 8'h00, 8, 1'b0, 1'b1);
        send_frame(8'hFF, 8'h00, 3, 1'b0, 1'b1);
        send_frame(8'h01, 8'h0C, 16, 1'b0, 1'b1);
        check(4, 3'b011);

        // R4: repeated arm still arms
        send_frame(8'h50, 8'h00, 8, 1'b1, 1'b1);
        send_frame(8'h50, 8'h00, 8, 1'b1, 1'b1);
        send_frame(8'h01, 8'h00, 16, 1'b1, 1'b1);
        check(4, 3'b000);

        // R8: lock set, then wp raised mid-frame -> judged at cs rise, accepted
        send_frame(8'h50, 8'h00, 8, 1'b0, 1'b1);
        send_frame(8'h01, 8'h80, 16, 1'b0, 1'b1);
        check(7, 3'b100);
        wp_n = 1'b0;
        send_frame(8'h50, 8'h00, 8, 1'b0, 1'b0);
        send_frame(8'h01, 8'h04, 16, 1'b0, 1'b1);
        check(8, 3'b001);

        // R8: lock set, wp dropped mid-frame -> blocked at cs rise
        wp_n = 1'b1;
        send_frame(8'h50, 8'h00, 8, 1'b0, 1'b1);
        send_frame(8'h01, 8'h80, 16, 1'b0, 1'b1);
        check(7, 3'b100);
        send_frame(8'h50, 8'h00, 8, 1'b0, 1'b1);
        send_frame(8'h01, 8'h00, 16, 1'b0, 1'b0);
        check(8, 3'b100);

        // R1: reset clears lock and a pending arm
        wp_n = 1'b1;
        send_frame(8'h50, 8'h00, 8, 1'b0, 1'b1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(1, 3'b011);
        send_frame(8'h01, 8'h00, 16, 1'b0, 1'b1);
        check(1, 3'b011);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule